// File: doc/BRIEF.md
# Memory Request Arbiter with Rotating Token

This block decides which of three requesters may use a shared memory-controller request channel. The requesters are a high-priority write-buffer flush, a processor path and a PCI-to-memory path. Each one presents a start address, a write/read flag and a transfer size of one, two or four doublewords. The arbiter takes one request at a time and places it on the channel. Besides the access in progress, the channel holds one more pipelined request, and its start address is visible to the memory side early.

A flush request always wins. The processor and PCI paths share a token that alternates between them. The token moves only when a processor or PCI access completes, and after reset it favours the processor. For the access in progress, the arbiter produces every doubleword beat address. A four-beat transfer runs to the end of its 32-byte line and then wraps to the start of that line. A two-beat transfer wraps the same way inside its 16-byte half-line. The memory side acknowledges each beat with one input.

Top module: `mem_req_arbiter`

## Requirements
- R1: After reset, mc_valid and mc_pend_valid are low, no grant is given while no request is present, and the token favours the processor.
- R2: When the flush request is present and a grant is given in that cycle, the grant goes to the flush source, whatever the other requests are.
- R3: When only the processor and PCI requests compete, the source holding the token receives the grant.
- R4: The token passes to the other source when a processor or PCI access completes its last beat. Completion of a flush access leaves the token where it was.
- R5: Grants are one-cycle pulses on flush_gnt, cpu_gnt and pci_gnt. At most one grant is active, and only to a source whose request is high. A grant is given only in a cycle where the pipelined slot is empty. The granted request becomes the active access if the channel is idle or finishing, and otherwise fills the pipelined slot.
- R6: While a request waits in the pipelined slot, mc_pend_valid is high and mc_pend_addr shows its start address with bits [2:0] cleared. When the active access completes, the pipelined request becomes active in the next cycle.
- R7: A size code of 0 (one doubleword) gives one beat at the start address with bits [2:0] cleared, with mc_last high.
- R8: A size code of 1 (two doublewords) gives two beats. The doubleword index in address bits [3] toggles inside the 16-byte half-line, and mc_last is high on the second beat.
- R9: A size code of 2 (four doublewords) gives four beats. Address bits [4:3] start at the requested doubleword and increment modulo 4, so the upper address bits never leave the 32-byte line. mc_last is high on the fourth beat.
- R10: mc_wr and mc_src reflect the active access. The source codes are flush=0, processor=1 and PCI=2.
- R11: A size code of 3 is treated as a one-doubleword transfer.
- R12: A beat address is held on mc_addr until mc_ack is high in a cycle where mc_valid is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_req | input | 1 | Flush source request |
| flush_addr | input | ADDR_W | Flush start address |
| flush_wr | input | 1 | Flush direction, 1 = write |
| flush_size | input | 2 | Flush size code |
| flush_gnt | output | 1 | Flush grant pulse |
| cpu_req | input | 1 | Processor request |
| cpu_addr | input | ADDR_W | Processor start address |
| cpu_wr | input | 1 | Processor direction, 1 = write |
| cpu_size | input | 2 | Processor size code |
| cpu_gnt | output | 1 | Processor grant pulse |
| pci_req | input | 1 | PCI request |
| pci_addr | input | ADDR_W | PCI start address |
| pci_wr | input | 1 | PCI direction, 1 = write |
| pci_size | input | 2 | PCI size code |
| pci_gnt | output | 1 | PCI grant pulse |
| mc_valid | output | 1 | Active access present |
| mc_addr | output | ADDR_W | Current beat address |
| mc_wr | output | 1 | Direction of active access |
| mc_src | output | 2 | Source code of active access |
| mc_last | output | 1 | Current beat is the final one |
| mc_ack | input | 1 | Memory accepted the current beat |
| mc_pend_valid | output | 1 | Pipelined request waiting |
| mc_pend_addr | output | ADDR_W | Start address of pipelined request |

## Verification
Arbitration is tried with three patterns. In the first, all three sources request together: only flush wins, which shows absolute priority. In the second, processor and PCI request together from reset: the processor wins, which shows the default token. In the third, the same pair requests again after a processor completion and again after a flush completion. These two results separate a token that rotates from one that is fixed, and show whether a flush completion moves the token. Beat addressing uses a four-beat start in mid-line, a two-beat start in the upper doubleword of a half-line, a misaligned single beat and the reserved size code. Together they distinguish line wrap from linear increment and half-line wrap from full-line wrap. A request that arrives while the pipelined slot is full confirms that no grant is given until the slot drains.

// File: rtl/mra_pkg.sv
package mra_pkg;

    localparam int NUM_SRC = 3;

    typedef enum logic [1:0] {
        SRC_FLUSH = 2'd0,
        SRC_CPU   = 2'd1,
        SRC_PCI   = 2'd2
    } src_e;

    typedef enum logic [1:0] {
        SZ_ONE  = 2'd0,
        SZ_TWO  = 2'd1,
        SZ_FOUR = 2'd2,
        SZ_RSV  = 2'd3
    } size_e;

    typedef struct packed {
        src_e  src;
        logic  wr;
        size_e size;
    } req_meta_t;

    // index of the final beat for a size code
    function automatic logic [1:0] final_beat(input size_e sz);
        case (sz)
            SZ_TWO:  final_beat = 2'd1;
            SZ_FOUR: final_beat = 2'd3;
            default: final_beat = 2'd0;
        endcase
    endfunction

    // doubleword index inside the 32-byte line for beat number cnt
    function automatic logic [1:0] wrap_index(input logic [1:0] start,
                                              input size_e sz,
                                              input logic [1:0] cnt);
        case (sz)
            SZ_FOUR: wrap_index = start + cnt;
            SZ_TWO:  wrap_index = {start[1], start[0] ^ cnt[0]};
            default: wrap_index = start;
        endcase
    endfunction

endpackage

// File: rtl/mra_pick.sv
module mra_pick
    import mra_pkg::*;
(
    input  logic [NUM_SRC-1:0] req,
    input  logic               token_pci,
    input  logic               enable,
    output logic [NUM_SRC-1:0] gnt
);
    always_comb begin
        gnt = '0;
        if (enable) begin
            if (req[SRC_FLUSH]) begin
                gnt[SRC_FLUSH] = 1'b1;
            end else if (req[SRC_CPU] && req[SRC_PCI]) begin
                if (token_pci) gnt[SRC_PCI] = 1'b1;
                else           gnt[SRC_CPU] = 1'b1;
            end else if (req[SRC_CPU]) begin
                gnt[SRC_CPU] = 1'b1;
            end else if (req[SRC_PCI]) begin
                gnt[SRC_PCI] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/mra_beat_gen.sv
module mra_beat_gen
    import mra_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              act_v,
    input  logic [ADDR_W-1:0] start_addr,
    input  size_e             size,
    input  logic              ack,
    output logic [ADDR_W-1:0] beat_addr,
    output logic              last
);
    localparam int LINE_LSB = 5;
    localparam int DW_LSB   = 3;

    logic [1:0] cnt;

    assign last      = (cnt == final_beat(size));
    assign beat_addr = {start_addr[ADDR_W-1:LINE_LSB],
                        wrap_index(start_addr[LINE_LSB-1:DW_LSB], size, cnt),
                        {DW_LSB{1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (act_v && ack) begin
            cnt <= last ? 2'd0 : cnt + 2'd1;
        end
    end
endmodule

// File: rtl/mem_req_arbiter.sv
module mem_req_arbiter
    import mra_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush_req,
    input  logic [ADDR_W-1:0] flush_addr,
    input  logic              flush_wr,
    input  logic [1:0]        flush_size,
    output logic              flush_gnt,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic [1:0]        cpu_size,
    output logic              cpu_gnt,
    input  logic              pci_req,
    input  logic [ADDR_W-1:0] pci_addr,
    input  logic              pci_wr,
    input  logic [1:0]        pci_size,
    output logic              pci_gnt,
    output logic              mc_valid,
    output logic [ADDR_W-1:0] mc_addr,
    output logic              mc_wr,
    output logic [1:0]        mc_src,
    output logic              mc_last,
    input  logic              mc_ack,
    output logic              mc_pend_valid,
    output logic [ADDR_W-1:0] mc_pend_addr
);
    localparam int DW_LSB = 3;

    logic [NUM_SRC-1:0] req_vec;
    logic [NUM_SRC-1:0] gnt_vec;
    logic [ADDR_W-1:0]  in_addr [NUM_SRC];
    req_meta_t          in_meta [NUM_SRC];

    assign req_vec[SRC_FLUSH] = flush_req;
    assign req_vec[SRC_CPU]   = cpu_req;
    assign req_vec[SRC_PCI]   = pci_req;

    assign in_addr[SRC_FLUSH] = flush_addr;
    assign in_addr[SRC_CPU]   = cpu_addr;
    assign in_addr[SRC_PCI]   = pci_addr;

    assign in_meta[SRC_FLUSH] = '{src: SRC_FLUSH, wr: flush_wr, size: size_e'(flush_size)};
    assign in_meta[SRC_CPU]   = '{src: SRC_CPU,   wr: cpu_wr,   size: size_e'(cpu_size)};
    assign in_meta[SRC_PCI]   = '{src: SRC_PCI,   wr: pci_wr,   size: size_e'(pci_size)};

    logic              act_v, pipe_v, token_pci;
    logic [ADDR_W-1:0] act_addr, pipe_addr;
    req_meta_t         act_meta, pipe_meta;
    logic              beat_last, done, act_free, any_gnt;
    logic [ADDR_W-1:0] sel_addr;
    req_meta_t         sel_meta;

    mra_pick u_pick (
        .req       (req_vec),
        .token_pci (token_pci),
        .enable    (!pipe_v),
        .gnt       (gnt_vec)
    );

    always_comb begin
        sel_addr = '0;
        sel_meta = '{src: SRC_FLUSH, wr: 1'b0, size: SZ_ONE};
        for (int i = 0; i < NUM_SRC; i++) begin
            if (gnt_vec[i]) begin
                sel_addr = in_addr[i];
                sel_meta = in_meta[i];
            end
        end
    end

    assign any_gnt  = |gnt_vec;
    assign done     = act_v && mc_ack && beat_last;
    assign act_free = !act_v || done;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_v     <= 1'b0;
            pipe_v    <= 1'b0;
            token_pci <= 1'b0;
            act_addr  <= '0;
            pipe_addr <= '0;
            act_meta  <= '{src: SRC_FLUSH, wr: 1'b0, size: SZ_ONE};
            pipe_meta <= '{src: SRC_FLUSH, wr: 1'b0, size: SZ_ONE};
        end else begin
            if (done && act_meta.src != SRC_FLUSH) begin
                token_pci <= (act_meta.src == SRC_CPU);
            end
            if (act_free) begin
                if (pipe_v) begin
                    act_v    <= 1'b1;
                    act_addr <= pipe_addr;
                    act_meta <= pipe_meta;
                    pipe_v   <= 1'b0;
                end else if (any_gnt) begin
                    act_v    <= 1'b1;
                    act_addr <= sel_addr;
                    act_meta <= sel_meta;
                end else begin
                    act_v    <= 1'b0;
                end
            end else if (any_gnt) begin
                pipe_v    <= 1'b1;
                pipe_addr <= sel_addr;
                pipe_meta <= sel_meta;
            end
        end
    end

    mra_beat_gen #(.ADDR_W(ADDR_W)) u_beat (
        .clk        (clk),
        .rst        (rst),
        .act_v      (act_v),
        .start_addr (act_addr),
        .size       (act_meta.size),
        .ack        (mc_ack),
        .beat_addr  (mc_addr),
        .last       (beat_last)
    );

    assign flush_gnt     = gnt_vec[SRC_FLUSH];
    assign cpu_gnt       = gnt_vec[SRC_CPU];
    assign pci_gnt       = gnt_vec[SRC_PCI];
    assign mc_valid      = act_v;
    assign mc_wr         = act_meta.wr;
    assign mc_src        = act_meta.src;
    assign mc_last       = beat_last;
    assign mc_pend_valid = pipe_v;
    assign mc_pend_addr  = {pipe_addr[ADDR_W-1:DW_LSB], {DW_LSB{1'b0}}};
endmodule

// File: rtl/mra_checker.sv
module mra_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              flush_req,
    input logic              cpu_req,
    input logic              pci_req,
    input logic              flush_gnt,
    input logic              cpu_gnt,
    input logic              pci_gnt,
    input logic              mc_valid,
    input logic [ADDR_W-1:0] mc_addr,
    input logic [1:0]        mc_src,
    input logic              mc_last,
    input logic              mc_ack,
    input logic              mc_pend_valid,
    input logic [ADDR_W-1:0] mc_pend_addr
);
    // R5
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({flush_gnt, cpu_gnt, pci_gnt}));

    // R5
    gnt_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        (flush_gnt || cpu_gnt || pci_gnt) |->
        ((!flush_gnt || flush_req) && (!cpu_gnt || cpu_req) && (!pci_gnt || pci_req)));

    // R5
    gnt_slot_free_chk: assert property (@(posedge clk) disable iff (rst)
        (flush_gnt || cpu_gnt || pci_gnt) |-> !mc_pend_valid);

    // R2
    flush_first_chk: assert property (@(posedge clk) disable iff (rst)
        (flush_req && (cpu_gnt || pci_gnt || flush_gnt)) |-> flush_gnt);

    // R6
    pend_behind_act_chk: assert property (@(posedge clk) disable iff (rst)
        mc_pend_valid |-> mc_valid);

    // R6
    pend_promote_chk: assert property (@(posedge clk) disable iff (rst)
        (mc_valid && mc_ack && mc_last && mc_pend_valid) |=>
        (mc_valid && mc_addr == $past(mc_pend_addr)));

    // R12
    beat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mc_valid && !mc_ack) |=> (mc_valid && $stable(mc_addr) && $stable(mc_src)));

    // R9
    line_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (mc_valid && mc_ack && !mc_last) |=>
        (mc_valid && mc_addr[ADDR_W-1:5] == $past(mc_addr[ADDR_W-1:5])));
endmodule

bind mem_req_arbiter mra_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .flush_req     (flush_req),
    .cpu_req       (cpu_req),
    .pci_req       (pci_req),
    .flush_gnt     (flush_gnt),
    .cpu_gnt       (cpu_gnt),
    .pci_gnt       (pci_gnt),
    .mc_valid      (mc_valid),
    .mc_addr       (mc_addr),
    .mc_src        (mc_src),
    .mc_last       (mc_last),
    .mc_ack        (mc_ack),
    .mc_pend_valid (mc_pend_valid),
    .mc_pend_addr  (mc_pend_addr)
);

// File: tb/mem_req_arbiter_tb_top.sv
module mem_req_arbiter_tb_top;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          flush_req, flush_wr, cpu_req, cpu_wr, pci_req, pci_wr;
    logic [AW-1:0] flush_addr, cpu_addr, pci_addr;
    logic [1:0]    flush_size, cpu_size, pci_size;
    logic          flush_gnt, cpu_gnt, pci_gnt;
    logic          mc_valid, mc_wr, mc_last, mc_ack, mc_pend_valid;
    logic [AW-1:0] mc_addr, mc_pend_addr;
    logic [1:0]    mc_src;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    mem_req_arbiter #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst),
        .flush_req(flush_req), .flush_addr(flush_addr), .flush_wr(flush_wr),
        .flush_size(flush_size), .flush_gnt(flush_gnt),
        .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .cpu_size(cpu_size), .cpu_gnt(cpu_gnt),
        .pci_req(pci_req), .pci_addr(pci_addr), .pci_wr(pci_wr),
        .pci_size(pci_size), .pci_gnt(pci_gnt),
        .mc_valid(mc_valid), .mc_addr(mc_addr), .mc_wr(mc_wr), .mc_src(mc_src),
        .mc_last(mc_last), .mc_ack(mc_ack),
        .mc_pend_valid(mc_pend_valid), .mc_pend_addr(mc_pend_addr)
    );

    task automatic chk(input string rq, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s got=%0h exp=%0h", rq, what, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic clear_inputs();
        flush_req = 0; flush_wr = 0; flush_addr = '0; flush_size = 2'd0;
        cpu_req = 0; cpu_wr = 0; cpu_addr = '0; cpu_size = 2'd0;
        pci_req = 0; pci_wr = 0; pci_addr = '0; pci_size = 2'd0;
        mc_ack = 0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        clear_inputs();
        repeat (2) @(posedge clk);
        #2;
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        #1;
        chk("R1", "mc_valid", mc_valid, 0);
        chk("R1", "mc_pend_valid", mc_pend_valid, 0);
        chk("R1", "grants", {flush_gnt, cpu_gnt, pci_gnt}, 0);
        tick(); #1;
        chk("R1", "mc_valid idle", mc_valid, 0);
    endtask

    task automatic t_token_and_pipe();
        do_reset();
        cpu_req = 1; cpu_addr = 32'h40; cpu_wr = 1; cpu_size = 2'd0;
        pci_req = 1; pci_addr = 32'h80; pci_wr = 0; pci_size = 2'd0;
        #1;
        chk("R3", "cpu_gnt default token", cpu_gnt, 1);
        chk("R3", "pci_gnt default token", pci_gnt, 0);
        tick(); cpu_req = 0; #1;
        chk("R10", "mc_src cpu", mc_src, 1);
        chk("R7", "mc_addr cpu", mc_addr, 32'h40);
        chk("R5", "pci_gnt into pend slot", pci_gnt, 1);
        tick(); pci_req = 0; #1;
        chk("R6", "mc_pend_valid", mc_pend_valid, 1);
        chk("R6", "mc_pend_addr", mc_pend_addr, 32'h80);
        chk("R6", "mc_src still cpu", mc_src, 1);
        mc_ack = 1;
        tick();
        mc_ack = 0;
        cpu_req = 1; pci_req = 1; pci_addr = 32'hC0;
        #1;
        chk("R6", "promoted src", mc_src, 2);
        chk("R6", "promoted addr", mc_addr, 32'h80);
        chk("R6", "pend drained", mc_pend_valid, 0);
        chk("R4", "pci_gnt after cpu done", pci_gnt, 1);
        chk("R4", "cpu_gnt after cpu done", cpu_gnt, 0);
        tick(); pci_req = 0; #1;
        chk("R5", "no grant while pend full", cpu_gnt, 0);
        cpu_req = 0;
    endtask

    task automatic t_flush_priority();
        do_reset();
        flush_req = 1; flush_addr = 32'h105; flush_wr = 1; flush_size = 2'd0;
        cpu_req = 1; cpu_addr = 32'h200; cpu_size = 2'd0;
        pci_req = 1; pci_addr = 32'h300; pci_size = 2'd0;
        #1;
        chk("R2", "flush_gnt", flush_gnt, 1);
        chk("R2", "cpu/pci gnt", {cpu_gnt, pci_gnt}, 0);
        tick(); flush_req = 0; #1;
        chk("R10", "mc_src flush", mc_src, 0);
        chk("R7", "single aligned addr", mc_addr, 32'h100);
        chk("R7", "single last", mc_last, 1);
        chk("R10", "mc_wr flush", mc_wr, 1);
        chk("R3", "cpu wins pend", cpu_gnt, 1);
        tick(); cpu_req = 0; pci_req = 0; mc_ack = 1;
        tick(); mc_ack = 0;
        cpu_req = 1; pci_req = 1;
        #1;
        chk("R10", "mc_src cpu after flush", mc_src, 1);
        chk("R4", "token kept after flush cpu_gnt", cpu_gnt, 1);
        chk("R4", "token kept after flush pci_gnt", pci_gnt, 0);
        tick(); cpu_req = 0; pci_req = 0;
    endtask

    task automatic t_quad_wrap();
        logic [AW-1:0] exp_a [3];
        exp_a[0] = 32'h1000_0018; exp_a[1] = 32'h1000_0000; exp_a[2] = 32'h1000_0008;
        do_reset();
        cpu_req = 1; cpu_addr = 32'h1000_0010; cpu_wr = 1; cpu_size = 2'd2;
        #1;
        chk("R5", "cpu_gnt quad", cpu_gnt, 1);
        tick(); cpu_req = 0; #1;
        chk("R9", "quad beat0", mc_addr, 32'h1000_0010);
        chk("R9", "quad beat0 last", mc_last, 0);
        chk("R10", "quad wr", mc_wr, 1);
        tick(); #1;
        chk("R12", "hold without ack", mc_addr, 32'h1000_0010);
        mc_ack = 1;
        for (int i = 0; i < 3; i++) begin
            tick(); #1;
            chk("R9", "quad beat addr", mc_addr, exp_a[i]);
            chk("R9", "quad last flag", mc_last, (i == 2));
        end
        tick(); mc_ack = 0; #1;
        chk("R9", "quad ends", mc_valid, 0);
    endtask

    task automatic t_double_wrap();
        do_reset();
        pci_req = 1; pci_addr = 32'h2000_001C; pci_wr = 0; pci_size = 2'd1;
        #1;
        chk("R5", "pci_gnt double", pci_gnt, 1);
        tick(); pci_req = 0; #1;
        chk("R8", "double beat0", mc_addr, 32'h2000_0018);
        chk("R8", "double beat0 last", mc_last, 0);
        chk("R10", "double src pci", mc_src, 2);
        chk("R10", "double rd", mc_wr, 0);
        mc_ack = 1;
        tick(); #1;
        chk("R8", "double beat1", mc_addr, 32'h2000_0010);
        chk("R8", "double beat1 last", mc_last, 1);
        tick(); mc_ack = 0; #1;
        chk("R8", "double ends", mc_valid, 0);
    endtask

    task automatic t_reserved_size();
        do_reset();
        cpu_req = 1; cpu_addr = 32'h48; cpu_size = 2'd3;
        tick(); cpu_req = 0; #1;
        chk("R11", "size3 addr", mc_addr, 32'h48);
        chk("R11", "size3 last", mc_last, 1);
        mc_ack = 1;
        tick(); mc_ack = 0; #1;
        chk("R11", "size3 one beat", mc_valid, 0);
    endtask

    initial begin
        rst = 1'b1;
        clear_inputs();
        t_reset_state();
        t_token_and_pipe();
        t_flush_priority();
        t_quad_wrap();
        t_double_wrap();
        t_reserved_size();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule